// File: doc/BRIEF.md
# Two-Pointer DMA Channel Engine

This block is one memory-to-memory DMA channel. It keeps two 20-bit address pointers, a 16-bit byte counter, a 16-bit control word and two width flags. The control word decides which pointer feeds data and which one receives it, whether each fetch waits for a source request line or each store waits for a destination request line, and whether the channel stops when the byte counter reaches zero. When the two sides differ in width, the engine packs bytes into words or splits words into bytes inside its own state machine. A single holding register carries the data between the fetch and the store.

A host sequencer loads the registers through a small load port while the channel is idle. It arms the channel with `go`. The channel becomes active only on the next sequencer instruction, which the sequencer signals with `seq_step`. The engine then drives a simple request/ready memory port. When the count termination fires, it pulses `done`, puts a resume offset on `resume_off` for the sequencer to add to its task pointer, and hands control back by raising `task_run`.

Top module: `dma2p_channel`

## Requirements
- R1: After a synchronous reset, `active` is 0, `task_run` is 1, `done` is 0, `mem_req` is 0 and `resume_off` is 0. No transfer is pending and the holding register is zero.
- R2: A `go` pulse only arms a pending flag, so `active` stays 0. The first `seq_step` after that sets `active` to 1 and clears `task_run` at the same clock edge. `active` and `task_run` are never both 1.
- R3: The load port writes a register when `ld_en` is 1 and the channel is inactive. `ld_sel` 0 selects pointer A, 1 selects pointer B, 2 selects the count (`ld_data[15:0]`), 3 selects the control word (`ld_data[15:0]`) and 4 selects the width flags (`ld_data[0]` = 16-bit destination, `ld_data[1]` = 16-bit source). Loads and `go` have no effect while `active` is 1.
- R4: Control bit 10 selects the source. When it is 0, pointer A is the source and pointer B the destination. When it is 1, the roles swap.
- R5: Every memory access keeps `mem_req`, `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` stable until `mem_rdy` is 1. A word access uses `mem_be`=11, with the low byte at the lower address. A byte access uses `mem_be`=01, with data on bits 7:0.
- R6: With a 16-bit source, each fetch is one word read. It adds 2 to the source pointer and subtracts 2 from the count. With an 8-bit source, each fetch reads one byte, adds 1 to the pointer and subtracts 1 from the count.
- R7: With an 8-bit source and a 16-bit destination, a fetch at an even count loads the byte into the low half of the holding register. A fetch at an odd count places the byte in the high half. Fetching continues until the count is even, and then one word is stored.
- R8: With a 16-bit source and an 8-bit destination, each word is stored as two byte writes: the low byte at the destination pointer, then the high byte at the next address.
- R9: The destination pointer advances by 2 after each word store and by 1 after each byte store.
- R10: When control bits 12:11 equal 1, no read is issued until `src_req` is 1 before each fetch.
- R11: When control bits 12:11 equal 2, no write is issued until `dst_req` is 1 before each store.
- R12: Control bits 4:3 hold the count termination code. The check runs once all bytes of a fetched unit have been stored. If the code is nonzero and the count is zero, the channel pulses `done` for one cycle, drives `resume_off` = (code−1)×4, clears `active` and sets `task_run`. Otherwise it begins the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register select for a load |
| ld_data | input | 20 | Load value |
| go | input | 1 | Arms a transfer |
| seq_step | input | 1 | One sequencer instruction has completed |
| src_req | input | 1 | Source request line |
| dst_req | input | 1 | Destination request line |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 2 | Byte strobes: 11 word, 01 byte |
| mem_addr | output | 20 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes this cycle |
| active | output | 1 | Transfer in progress |
| task_run | output | 1 | Sequencer owns the channel |
| done | output | 1 | One-cycle termination pulse |
| resume_off | output | 4 | Offset to add to the task pointer |

## Verification
The assertions check four things on every cycle: the memory request stays stable until ready, `active` and `task_run` exclude each other, memory is touched only while the channel is active, and `done` is a legal single-cycle pulse with a resume offset from the allowed set. The directed scenarios are the only way to show the data path at work. They cover source selection, packing and splitting between widths, pointer and count stepping visible in the written bytes and addresses, request-line stalls, that loads are ignored mid-transfer, and the offset computed from each termination code.

// File: rtl/dma2p_pkg.sv
package dma2p_pkg;
    localparam int unsigned PTR_W = 20;
    localparam int unsigned CNT_W = 16;
    localparam int unsigned DAT_W = 16;
    localparam int unsigned CTL_W = 16;
    localparam int unsigned OFF_W = 4;
    localparam int unsigned SEL_W = 3;

    // control word positions the engine decodes
    localparam int unsigned CTL_TBC_LO  = 3;
    localparam int unsigned CTL_SRCSEL  = 10;
    localparam int unsigned CTL_SYNC_LO = 11;

    localparam logic [1:0] SYNC_SRC = 2'd1;
    localparam logic [1:0] SYNC_DST = 2'd2;

    typedef enum logic [2:0] {
        S_HEAD, S_SRCW, S_RD, S_DSTW, S_WR, S_WRHI, S_CHK
    } st_e;

    typedef struct packed {
        st_e              st;
        logic [PTR_W-1:0] pa;
        logic [PTR_W-1:0] pb;
        logic [CNT_W-1:0] cnt;
        logic [CTL_W-1:0] ctl;
        logic             src16;
        logic             dst16;
        logic [DAT_W-1:0] hold;
        logic             hi;
        logic             pend;
        logic             act;
        logic             task_f;
        logic             done;
        logic [OFF_W-1:0] roff;
    } regs_t;
endpackage

// File: rtl/dma2p_lane.sv
module dma2p_lane
    import dma2p_pkg::*;
#(
    parameter int unsigned DW = DAT_W
) (
    input  st_e           st,
    input  logic          src16,
    input  logic          dst16,
    input  logic          cnt_odd,
    input  logic [DW-1:0] hold,
    input  logic [DW-1:0] rdata,
    output logic          req,
    output logic          we,
    output logic [1:0]    be,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] hold_nx
);
    localparam int unsigned BW = DW / 2;

    always_comb begin
        req   = (st == S_RD) || (st == S_WR) || (st == S_WRHI);
        we    = (st == S_WR) || (st == S_WRHI);
        be    = 2'b01;
        wdata = '0;
        if (st == S_RD) begin
            be = src16 ? 2'b11 : 2'b01;
        end else if (st == S_WR) begin
            be    = dst16 ? 2'b11 : 2'b01;
            wdata = dst16 ? hold : {{BW{1'b0}}, hold[BW-1:0]};
        end else if (st == S_WRHI) begin
            wdata = {{BW{1'b0}}, hold[DW-1:BW]};
        end
    end

    // assembled holding value for a completed read
    always_comb begin
        if (src16)
            hold_nx = rdata;
        else if (dst16 && cnt_odd)
            hold_nx = {rdata[BW-1:0], hold[BW-1:0]};
        else
            hold_nx = {{BW{1'b0}}, rdata[BW-1:0]};
    end
endmodule

// File: rtl/dma2p_channel.sv
module dma2p_channel
    import dma2p_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [PTR_W-1:0] ld_data,
    input  logic             go,
    input  logic             seq_step,
    input  logic             src_req,
    input  logic             dst_req,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_be,
    output logic [PTR_W-1:0] mem_addr,
    output logic [DAT_W-1:0] mem_wdata,
    input  logic [DAT_W-1:0] mem_rdata,
    input  logic             mem_rdy,
    output logic             active,
    output logic             task_run,
    output logic             done,
    output logic [OFF_W-1:0] resume_off
);
    regs_t q, d;

    logic             swap;
    logic [1:0]       sync;
    logic [1:0]       tbc;
    logic [PTR_W-1:0] src_ptr, dst_ptr;
    logic [DAT_W-1:0] hold_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic [PTR_W-1:0] src_step, dst_step;

    assign swap     = q.ctl[CTL_SRCSEL];
    assign sync     = q.ctl[CTL_SYNC_LO +: 2];
    assign tbc      = q.ctl[CTL_TBC_LO +: 2];
    assign src_ptr  = swap ? q.pb : q.pa;
    assign dst_ptr  = swap ? q.pa : q.pb;
    assign src_step = q.src16 ? PTR_W'(2) : PTR_W'(1);
    assign dst_step = (q.dst16 && q.st == S_WR) ? PTR_W'(2) : PTR_W'(1);
    assign cnt_nx   = q.cnt - (q.src16 ? CNT_W'(2) : CNT_W'(1));

    dma2p_lane #(.DW(DAT_W)) lane_i (
        .st      (q.st),
        .src16   (q.src16),
        .dst16   (q.dst16),
        .cnt_odd (q.cnt[0]),
        .hold    (q.hold),
        .rdata   (mem_rdata),
        .req     (mem_req),
        .we      (mem_we),
        .be      (mem_be),
        .wdata   (mem_wdata),
        .hold_nx (hold_nx)
    );

    assign mem_addr   = (q.st == S_RD) ? src_ptr : dst_ptr;
    assign active     = q.act;
    assign task_run   = q.task_f;
    assign done       = q.done;
    assign resume_off = q.roff;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.act) begin
            d.st = S_HEAD;
            if (ld_en) begin
                case (ld_sel)
                    3'd0:    d.pa  = ld_data;
                    3'd1:    d.pb  = ld_data;
                    3'd2:    d.cnt = ld_data[CNT_W-1:0];
                    3'd3:    d.ctl = ld_data[CTL_W-1:0];
                    3'd4:    {d.src16, d.dst16} = ld_data[1:0];
                    default: ;
                endcase
            end
            if (go)
                d.pend = 1'b1;
            if (seq_step && q.pend) begin
                d.pend   = 1'b0;
                d.act    = 1'b1;
                d.task_f = 1'b0;
            end
        end else begin
            case (q.st)
                S_HEAD: d.st = (sync == SYNC_SRC) ? S_SRCW : S_RD;
                S_SRCW: if (src_req) d.st = S_RD;
                S_RD: if (mem_rdy) begin
                    d.hold = hold_nx;
                    d.cnt  = cnt_nx;
                    if (swap) d.pb = q.pb + src_step;
                    else      d.pa = q.pa + src_step;
                    if (!q.src16 && q.dst16 && cnt_nx[0])
                        d.st = (sync == SYNC_SRC) ? S_SRCW : S_RD;
                    else
                        d.st = (sync == SYNC_DST) ? S_DSTW : S_WR;
                end
                S_DSTW: if (dst_req) d.st = q.hi ? S_WRHI : S_WR;
                S_WR: if (mem_rdy) begin
                    if (swap) d.pa = q.pa + dst_step;
                    else      d.pb = q.pb + dst_step;
                    if (q.src16 && !q.dst16) begin
                        d.hi = 1'b1;
                        d.st = (sync == SYNC_DST) ? S_DSTW : S_WRHI;
                    end else begin
                        d.st = S_CHK;
                    end
                end
                S_WRHI: if (mem_rdy) begin
                    if (swap) d.pa = q.pa + dst_step;
                    else      d.pb = q.pb + dst_step;
                    d.hi = 1'b0;
                    d.st = S_CHK;
                end
                S_CHK: begin
                    d.st = S_HEAD;
                    if (tbc != 2'd0 && q.cnt == '0) begin
                        d.act    = 1'b0;
                        d.task_f = 1'b1;
                        d.done   = 1'b1;
                        d.roff   = OFF_W'({tbc - 2'd1, 2'b00});
                    end
                end
                default: d.st = S_HEAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.st     <= S_HEAD;
            q.task_f <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dma2p_channel_chk.sv
module dma2p_channel_chk
    import dma2p_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mem_req,
    input logic             mem_we,
    input logic [1:0]       mem_be,
    input logic [PTR_W-1:0] mem_addr,
    input logic [DAT_W-1:0] mem_wdata,
    input logic             mem_rdy,
    input logic             active,
    input logic             task_run,
    input logic             done,
    input logic [OFF_W-1:0] resume_off
);
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_be) && $stable(mem_wdata)));

    a_r5_be_legal: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_be == 2'b11 || mem_be == 2'b01));

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(active && task_run));

    a_r2_req_only_active: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> active);

    a_r12_done_handback: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && task_run));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_off_legal: assert property (@(posedge clk) disable iff (rst)
        done |-> (resume_off == 4'd0 || resume_off == 4'd4 || resume_off == 4'd8));
endmodule

bind dma2p_channel dma2p_channel_chk chk_i (.*);

// File: tb/dma2p_channel_tb.sv
module dma2p_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [19:0] ld_data = '0;
    logic        go = 1'b0, seq_step = 1'b0;
    logic        src_req = 1'b0, dst_req = 1'b0;
    logic        mem_req, mem_we;
    logic [1:0]  mem_be;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic        active, task_run, done;
    logic [3:0]  resume_off;

    int vectors = 0, fails = 0;
    int reads = 0, writes = 0, wwords = 0;
    logic [7:0] mem [256];

    always #2 clk = ~clk;

    dma2p_channel dut_i (.*);

    // memory model: one-cycle latency, data visible with ready
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rdy) begin
                mem_rdy = 1'b0;
            end else if (mem_req) begin
                mem_rdy = 1'b1;
                if (mem_we) begin
                    writes++;
                    mem[mem_addr[7:0]] = mem_wdata[7:0];
                    if (mem_be == 2'b11) begin
                        wwords++;
                        mem[8'(mem_addr[7:0] + 8'd1)] = mem_wdata[15:8];
                    end
                end else begin
                    reads++;
                    mem_rdata = (mem_be == 2'b11)
                        ? {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]}
                        : {8'h00, mem[mem_addr[7:0]]};
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] sel, input logic [19:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic setup(input logic [19:0] a, input logic [19:0] b, input logic [15:0] n,
                         input logic [15:0] ctl, input logic [1:0] w);
        load(3'd0, a); load(3'd1, b); load(3'd2, {4'h0, n});
        load(3'd3, {4'h0, ctl}); load(3'd4, {18'h0, w});
        reads = 0; writes = 0; wwords = 0;
    endtask

    task automatic launch();
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 armed but not active", active, 1'b0);
        seq_step = 1'b1;
        @(negedge clk); seq_step = 1'b0;
        chk("R2 active after step", active, 1'b1);
        chk("R2 task_run cleared", task_run, 1'b0);
    endtask

    task automatic finish_wait(input logic [3:0] exp_off, input string tag);
        bit seen = 0;
        for (int i = 0; i < 500 && !seen; i++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        chk({tag, " done seen"}, seen, 1'b1);
        chk({tag, " resume offset"}, resume_off, exp_off);
        chk({tag, " active cleared"}, active, 1'b0);
        chk({tag, " task_run set"}, task_run, 1'b1);
    endtask

    task automatic cmp_bytes(input int src, input int dst, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (mem[8'(dst + i)] !== 8'(8'h10 + src + i)) bad++;
        chk({tag, " data copied"}, bad, 0);
    endtask

    task automatic t_reset();
        chk("R1 active", active, 1'b0);
        chk("R1 task_run", task_run, 1'b1);
        chk("R1 done", done, 1'b0);
        chk("R1 mem_req", mem_req, 1'b0);
        chk("R1 resume_off", resume_off, 4'd0);
    endtask

    task automatic t_byte_copy();      // R6 R9 R12 code 1, A source
        setup(20'h00004, 20'h00080, 16'd4, 16'h0008, 2'b00);
        launch();
        finish_wait(4'd0, "R12 code1");
        cmp_bytes(4, 8'h80, 4, "R6 byte");
        chk("R6 byte reads", reads, 4);
        chk("R9 byte writes", writes, 4);
    endtask

    task automatic t_word_swap();      // R4 R6 code 2
        setup(20'h00090, 20'h00010, 16'd4, 16'h0410, 2'b11);
        launch();
        finish_wait(4'd4, "R12 code2");
        cmp_bytes(8'h10, 8'h90, 4, "R4 swapped");
        chk("R6 word reads", reads, 2);
        chk("R9 word writes", wwords, 2);
    endtask

    task automatic t_pack();           // R7 code 3
        setup(20'h00020, 20'h000A0, 16'd4, 16'h0018, 2'b01);
        launch();
        finish_wait(4'd8, "R12 code3");
        cmp_bytes(8'h20, 8'hA0, 4, "R7 pack");
        chk("R7 byte reads", reads, 4);
        chk("R7 word writes", wwords, 2);
    endtask

    task automatic t_split();          // R8
        setup(20'h00030, 20'h000B0, 16'd4, 16'h0008, 2'b10);
        launch();
        finish_wait(4'd0, "R8");
        cmp_bytes(8'h30, 8'hB0, 4, "R8 split");
        chk("R8 reads", reads, 2);
        chk("R8 byte writes", writes, 4);
        chk("R8 no word writes", wwords, 0);
    endtask

    task automatic t_src_sync();       // R10 and R3 load ignored
        setup(20'h00008, 20'h000C0, 16'd2, 16'h0808, 2'b00);
        src_req = 1'b0;
        launch();
        load(3'd1, 20'h000E0);
        repeat (20) @(negedge clk);
        chk("R10 no read before src_req", reads, 0);
        chk("R10 still active", active, 1'b1);
        src_req = 1'b1;
        finish_wait(4'd0, "R10");
        src_req = 1'b0;
        cmp_bytes(8, 8'hC0, 2, "R3 pointer kept");
        chk("R3 ignored load untouched", mem[8'hE0], 8'h00);
    endtask

    task automatic t_dst_sync();       // R11
        setup(20'h0000C, 20'h000D0, 16'd2, 16'h1008, 2'b00);
        dst_req = 1'b0;
        launch();
        repeat (20) @(negedge clk);
        chk("R11 one read done", reads, 1);
        chk("R11 no write before dst_req", writes, 0);
        dst_req = 1'b1;
        finish_wait(4'd0, "R11");
        dst_req = 1'b0;
        cmp_bytes(8'h0C, 8'hD0, 2, "R11");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i < 64) ? 8'(8'h10 + i) : 8'h00;
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_byte_copy();
                t_word_swap();
                t_pack();
                t_split();
                t_src_sync();
                t_dst_sync();
            end
            begin
                repeat (100000) @(posedge clk);
                vectors++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule